// File: doc/BRIEF.md
# Two-Port Snooping Coherent Cache Pair

This block places a small direct-mapped write-back data cache in front of each of two processor ports. Both caches share a single bus to one backing memory, and a central snooping controller keeps them coherent. A static parameter selects the coherence policy for the whole instance. Under the invalidate policy, a write removes the copy held by the other cache. Under the update policy, the new data is pushed into the other cache's copy.

Each port issues word reads and writes. A port holds its request until the block raises a one-cycle ready, and read data is valid in that same cycle. A fixed-priority arbiter serves one request at a time, and port 0 wins when both ports ask in the same cycle.

Coherence is tracked per line of four words. Each line carries a state: Invalid, Shared, Exclusive or Modified. When one cache misses on a line that the other cache holds Modified, the owning cache supplies the line. That same bus cycle also writes the line back to memory, and both copies end up Shared. A bus transaction counter is exposed so that the traffic of the two policies can be compared.

Top module: `coh_pair`

## Requirements
- R1: After reset every line in both caches is Invalid, no port is ready and the bus counter is zero. The first read of any word returns the backing memory contents.
- R2: A port's ready is high for exactly one cycle per request, only while that port's request is high, and never for both ports in the same cycle. Read data is valid during that cycle.
- R3: A write that hits an Exclusive or Modified line updates only the cache. Backing memory keeps its old value and the bus counter does not change.
- R4: A read miss on a line that the other cache holds Modified returns the newest data from that cache. The same single bus transaction writes the line to memory, and both copies become Shared.
- R5: With the invalidate policy, a write to a Shared line takes one bus transaction, makes the writer's line Modified and removes the other copy. The other port's next read of that line misses and is supplied by the writer.
- R6: With the update policy, every write to a Shared line takes one bus transaction that overwrites the word in the other cache's copy and writes the full line to memory. The line stays Shared in both caches.
- R7: Coherence acts on whole four-word lines. Writes by the two ports to different words of one line still trigger the invalidation or update traffic of R5 or R6.
- R8: A miss whose victim line is Modified first writes the victim to memory in its own bus transaction and then fills. A clean victim is replaced with only the fill transaction.
- R9: When both ports raise a request in the same cycle, port 0 completes first.
- R10: The bus counter increases by exactly one for each cycle in which a bus transaction (fill, write-back, supply, invalidate or update) is issued.
- R11: A line is never Modified in one cache while the other cache holds a valid copy of the same line, under either policy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_req | input | 1 | Port 0 request, held until ready |
| p0_we | input | 1 | Port 0 write (1) or read (0) |
| p0_addr | input | ADDR_W | Port 0 word address |
| p0_wdata | input | DATA_W | Port 0 write word |
| p0_ready | output | 1 | Port 0 request complete |
| p0_rdata | output | DATA_W | Port 0 read word |
| p1_req | input | 1 | Port 1 request, held until ready |
| p1_we | input | 1 | Port 1 write (1) or read (0) |
| p1_addr | input | ADDR_W | Port 1 word address |
| p1_wdata | input | DATA_W | Port 1 write word |
| p1_ready | output | 1 | Port 1 request complete |
| p1_rdata | output | DATA_W | Port 1 read word |
| mem_req | output | 1 | Bus transaction this cycle |
| mem_we | output | 1 | Bus transaction writes memory |
| mem_addr | output | ADDR_W-log2(WORDS) | Line address |
| mem_wdata | output | WORDS*DATA_W | Line written to memory |
| mem_rdata | input | WORDS*DATA_W | Line read from memory, same cycle |
| bus_count | output | CNT_W | Bus transactions since reset |

## Verification
Both policies are driven with the same access sequence, and each instance is compared with a flat coherent model of memory. One case is a read by the other port straight after a private write. Here a design without cache-to-cache supply would return the stale memory word, and one that skipped the write-back would leave memory stale after the line became Shared. Writes to neighbouring words of one line check that traffic is counted per line: a per-word design would show too few bus transactions. An eviction of a dirty line checks that memory receives the victim before the new line is fetched. A simultaneous request from both ports checks that port 0 finishes first.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [1:0] {ST_I, ST_S, ST_E, ST_M} line_st_e;
    typedef enum logic [1:0] {PH_IDLE, PH_LOOK, PH_WB, PH_FILL} phase_e;
    typedef enum logic {POL_INVALIDATE, POL_UPDATE} policy_e;
endpackage

// File: rtl/coh_arb.sv
module coh_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    output logic [1:0] gnt
);
    // fixed priority, lower port wins
    always_comb begin
        gnt[0] = req[0];
        gnt[1] = req[1] & ~req[0];
    end

    p_grant_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    p_port0_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req == 2'b11) |-> gnt[0]);
endmodule

// File: rtl/coh_store.sv
module coh_store
    import coh_pkg::*;
#(
    parameter int SETS   = 4,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 4,
    parameter int LINE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output line_st_e          rd_st,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  line_st_e          wr_st,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line
);
    line_st_e          st_q   [SETS];
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] line_q [SETS];

    assign rd_st   = st_q[rd_idx];
    assign rd_tag  = tag_q[rd_idx];
    assign rd_line = line_q[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) st_q[i] <= ST_I;
        end else if (wr_en) begin
            st_q[rd_idx] <= wr_st;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[rd_idx]  <= wr_tag;
            line_q[rd_idx] <= wr_line;
        end
    end
endmodule

// File: rtl/coh_pair.sv
module coh_pair
    import coh_pkg::*;
#(
    parameter policy_e POLICY = POL_INVALIDATE,
    parameter int      ADDR_W = 8,
    parameter int      DATA_W = 16,
    parameter int      SETS   = 4,
    parameter int      WORDS  = 4,
    parameter int      CNT_W  = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               p0_req,
    input  logic                               p0_we,
    input  logic [ADDR_W-1:0]                  p0_addr,
    input  logic [DATA_W-1:0]                  p0_wdata,
    output logic                               p0_ready,
    output logic [DATA_W-1:0]                  p0_rdata,
    input  logic                               p1_req,
    input  logic                               p1_we,
    input  logic [ADDR_W-1:0]                  p1_addr,
    input  logic [DATA_W-1:0]                  p1_wdata,
    output logic                               p1_ready,
    output logic [DATA_W-1:0]                  p1_rdata,
    output logic                               mem_req,
    output logic                               mem_we,
    output logic [ADDR_W-$clog2(WORDS)-1:0]    mem_addr,
    output logic [WORDS*DATA_W-1:0]            mem_wdata,
    input  logic [WORDS*DATA_W-1:0]            mem_rdata,
    output logic [CNT_W-1:0]                   bus_count
);
    localparam int OFF_W  = $clog2(WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int LINE_W = WORDS * DATA_W;

    typedef struct packed {
        phase_e              ph;
        logic                port;
        logic                we;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [CNT_W-1:0]    cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [1:0]        req_v, gnt;
    line_st_e          rd_st   [2];
    logic [TAG_W-1:0]  rd_tag  [2];
    logic [LINE_W-1:0] rd_line [2];
    logic              wr_en   [2];
    line_st_e          wr_st   [2];
    logic [TAG_W-1:0]  wr_tag  [2];
    logic [LINE_W-1:0] wr_line [2];
    logic [1:0]        rdy;
    logic [DATA_W-1:0] rdata;

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [OFF_W-1:0]  off;
    logic              me, oth, my_hit, ot_hit;
    logic [LINE_W-1:0] my_merged, ot_merged;

    assign req_v = {p1_req, p0_req};

    coh_arb u_arb (.clk(clk), .rst_n(rst_n), .req(req_v), .gnt(gnt));

    for (genvar c = 0; c < 2; c++) begin : g_cache
        coh_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
            .clk(clk), .rst_n(rst_n), .rd_idx(idx),
            .rd_st(rd_st[c]), .rd_tag(rd_tag[c]), .rd_line(rd_line[c]),
            .wr_en(wr_en[c]), .wr_st(wr_st[c]), .wr_tag(wr_tag[c]), .wr_line(wr_line[c])
        );
    end

    always_comb begin
        ctl_d = ctl_q;
        idx   = ctl_q.addr[OFF_W +: IDX_W];
        tag   = ctl_q.addr[ADDR_W-1 -: TAG_W];
        off   = ctl_q.addr[OFF_W-1:0];
        me    = ctl_q.port;
        oth   = ~ctl_q.port;
        my_hit = (rd_st[me]  != ST_I) && (rd_tag[me]  == tag);
        ot_hit = (rd_st[oth] != ST_I) && (rd_tag[oth] == tag);
        my_merged = rd_line[me];
        my_merged[off*DATA_W +: DATA_W] = ctl_q.wdata;
        ot_merged = rd_line[oth];
        ot_merged[off*DATA_W +: DATA_W] = ctl_q.wdata;
        rdata = rd_line[me][off*DATA_W +: DATA_W];
        for (int c = 0; c < 2; c++) begin
            wr_en[c]   = 1'b0;
            wr_st[c]   = rd_st[c];
            wr_tag[c]  = rd_tag[c];
            wr_line[c] = rd_line[c];
        end
        rdy       = 2'b00;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {tag, idx};
        mem_wdata = rd_line[me];

        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (|req_v) begin
                    ctl_d.ph    = PH_LOOK;
                    ctl_d.port  = gnt[1];
                    ctl_d.we    = gnt[1] ? p1_we    : p0_we;
                    ctl_d.addr  = gnt[1] ? p1_addr  : p0_addr;
                    ctl_d.wdata = gnt[1] ? p1_wdata : p0_wdata;
                end
            end
            PH_LOOK: begin
                if (my_hit) begin
                    rdy[me]  = 1'b1;
                    ctl_d.ph = PH_IDLE;
                    if (ctl_q.we) begin
                        wr_en[me]   = 1'b1;
                        wr_line[me] = my_merged;
                        wr_st[me]   = ST_M;
                        if (rd_st[me] == ST_S) begin
                            mem_req = 1'b1;
                            if (POLICY == POL_INVALIDATE) begin
                                wr_en[oth] = ot_hit;
                                wr_st[oth] = ST_I;
                            end else begin
                                mem_we       = 1'b1;
                                mem_wdata    = my_merged;
                                wr_st[me]    = ST_S;
                                wr_en[oth]   = ot_hit;
                                wr_line[oth] = ot_merged;
                            end
                        end
                    end
                end else begin
                    ctl_d.ph = (rd_st[me] == ST_M) ? PH_WB : PH_FILL;
                end
            end
            PH_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {rd_tag[me], idx};
                wr_en[me] = 1'b1;
                wr_st[me] = ST_I;
                ctl_d.ph  = PH_FILL;
            end
            PH_FILL: begin
                mem_req    = 1'b1;
                wr_en[me]  = 1'b1;
                wr_tag[me] = tag;
                wr_en[oth] = ot_hit;
                wr_st[oth] = ST_S;
                if (ot_hit && rd_st[oth] == ST_M) begin
                    mem_we      = 1'b1;
                    mem_wdata   = rd_line[oth];
                    wr_line[me] = rd_line[oth];
                    wr_st[me]   = ST_S;
                end else begin
                    wr_line[me] = mem_rdata;
                    wr_st[me]   = ot_hit ? ST_S : ST_E;
                end
                ctl_d.ph = PH_LOOK;
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
        ctl_d.cnt = ctl_q.cnt + CNT_W'(mem_req);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_IDLE, port: 1'b0, we: 1'b0, addr: '0, wdata: '0, cnt: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign p0_ready  = rdy[0];
    assign p1_ready  = rdy[1];
    assign p0_rdata  = rdata;
    assign p1_rdata  = rdata;
    assign bus_count = ctl_q.cnt;

    p_one_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({p1_ready, p0_ready}));
    p_ready_p0_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        p0_ready |-> p0_req);
    p_ready_p1_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        p1_ready |-> p1_req);
    p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> (bus_count == $past(bus_count) + CNT_W'(1)));
    p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |=> $stable(bus_count));

    for (genvar s = 0; s < SETS; s++) begin : g_owner_chk
        p_single_owner_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !(g_cache[0].u_store.tag_q[s] == g_cache[1].u_store.tag_q[s] &&
              ((g_cache[0].u_store.st_q[s] == ST_M && g_cache[1].u_store.st_q[s] != ST_I) ||
               (g_cache[1].u_store.st_q[s] == ST_M && g_cache[0].u_store.st_q[s] != ST_I))));
    end
endmodule

// File: tb/coh_pair_tb.sv
module coh_pair_tb;
    import coh_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // stimulus shared by both instances per port; request per instance
    logic        req   [2][2];
    logic        pw    [2];
    logic [7:0]  pa    [2];
    logic [15:0] pd    [2];
    logic        rdy   [2][2];
    logic [15:0] rdat  [2][2];
    logic        mreq  [2];
    logic        mwe   [2];
    logic [5:0]  maddr [2];
    logic [63:0] mwdat [2];
    logic [63:0] mrdat [2];
    logic [15:0] bcnt  [2];
    logic [15:0] mem   [2][256];
    logic [15:0] ref_mem [256];
    logic [15:0] sb_q  [4][$];
    time         t_done [2][2];

    coh_pair #(.POLICY(POL_INVALIDATE)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .p0_req(req[0][0]), .p0_we(pw[0]), .p0_addr(pa[0]), .p0_wdata(pd[0]),
        .p0_ready(rdy[0][0]), .p0_rdata(rdat[0][0]),
        .p1_req(req[0][1]), .p1_we(pw[1]), .p1_addr(pa[1]), .p1_wdata(pd[1]),
        .p1_ready(rdy[0][1]), .p1_rdata(rdat[0][1]),
        .mem_req(mreq[0]), .mem_we(mwe[0]), .mem_addr(maddr[0]),
        .mem_wdata(mwdat[0]), .mem_rdata(mrdat[0]), .bus_count(bcnt[0]));

    coh_pair #(.POLICY(POL_UPDATE)) u_dut_upd (
        .clk(clk), .rst_n(rst_n),
        .p0_req(req[1][0]), .p0_we(pw[0]), .p0_addr(pa[0]), .p0_wdata(pd[0]),
        .p0_ready(rdy[1][0]), .p0_rdata(rdat[1][0]),
        .p1_req(req[1][1]), .p1_we(pw[1]), .p1_addr(pa[1]), .p1_wdata(pd[1]),
        .p1_ready(rdy[1][1]), .p1_rdata(rdat[1][1]),
        .mem_req(mreq[1]), .mem_we(mwe[1]), .mem_addr(maddr[1]),
        .mem_wdata(mwdat[1]), .mem_rdata(mrdat[1]), .bus_count(bcnt[1]));

    // single-cycle backing memories, one per instance
    always_comb begin
        for (int d = 0; d < 2; d++)
            for (int k = 0; k < 4; k++)
                mrdat[d][k*16 +: 16] = mem[d][{maddr[d], k[1:0]}];
    end

    always @(posedge clk) begin
        for (int d = 0; d < 2; d++)
            if (mreq[d] && mwe[d])
                for (int k = 0; k < 4; k++)
                    mem[d][{maddr[d], k[1:0]}] <= mwdat[d][k*16 +: 16];
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // scoreboard monitor: pops expected read words when a read completes
    always @(negedge clk) begin
        for (int d = 0; d < 2; d++)
            for (int p = 0; p < 2; p++)
                if (rst_n && rdy[d][p] && !pw[p]) begin
                    if (sb_q[d*2+p].size() == 0) begin
                        chk(1'b0, "R2 unexpected read ready", 1, 0);
                    end else begin
                        logic [15:0] e;
                        e = sb_q[d*2+p].pop_front();
                        chk(rdat[d][p] == e, "R4 read data (R1 R5 R6 R7)", int'(rdat[d][p]), int'(e));
                    end
                end
    end

    task automatic wait_rdy(input int d, input int p);
        forever begin
            @(negedge clk);
            if (rdy[d][p]) break;
        end
        t_done[d][p] = $time;
        @(posedge clk);
        #1 req[d][p] = 1'b0;
    endtask

    task automatic issue(input int p, input bit we, input logic [7:0] a, input logic [15:0] v);
        pw[p] = we; pa[p] = a; pd[p] = v;
        if (we) ref_mem[a] = v;
        else begin
            sb_q[p].push_back(ref_mem[a]);
            sb_q[2+p].push_back(ref_mem[a]);
        end
        req[0][p] = 1'b1;
        req[1][p] = 1'b1;
    endtask

    task automatic op(input int p, input bit we, input logic [7:0] a, input logic [15:0] v);
        @(negedge clk);
        issue(p, we, a, v);
        fork
            wait_rdy(0, p);
            wait_rdy(1, p);
        join
    endtask

    task automatic cnt_chk(input int ei, input int eu, input string rq);
        @(negedge clk);
        chk(bcnt[0] == 16'(ei), {rq, " bus count invalidate"}, int'(bcnt[0]), ei);
        chk(bcnt[1] == 16'(eu), {rq, " bus count update"}, int'(bcnt[1]), eu);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[0][i] = 16'h1000 + 16'(i);
            mem[1][i] = 16'h1000 + 16'(i);
            ref_mem[i] = 16'h1000 + 16'(i);
        end
        for (int p = 0; p < 2; p++) begin
            req[0][p] = 1'b0; req[1][p] = 1'b0;
            pw[p] = 1'b0; pa[p] = '0; pd[p] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!rdy[0][0] && !rdy[0][1] && !rdy[1][0] && !rdy[1][1], "R1 ready low after reset", 1, 0);
        chk(!mreq[0] && !mreq[1], "R1 bus idle after reset", 1, 0);
        cnt_chk(0, 0, "R1");

        op(1, 1'b0, 8'd0, '0);                 // R1 first read comes from memory
        cnt_chk(1, 1, "R1");
        op(1, 1'b1, 8'd0, 16'h0005);           // R3 private write
        cnt_chk(1, 1, "R3");
        chk(mem[0][0] == 16'h1000 && mem[1][0] == 16'h1000, "R3 memory stale after write", int'(mem[0][0]), 'h1000);
        op(0, 1'b0, 8'd0, '0);                 // R4 cache-to-cache supply
        cnt_chk(2, 2, "R4");
        chk(mem[0][0] == 16'h0005 && mem[1][0] == 16'h0005, "R4 supply writes back", int'(mem[0][0]), 5);
        op(1, 1'b1, 8'd0, 16'h0003);           // R5 / R6 write to shared line
        cnt_chk(3, 3, "R5 R6");
        chk(mem[0][0] == 16'h0005, "R5 invalidate keeps memory", int'(mem[0][0]), 5);
        chk(mem[1][0] == 16'h0003, "R6 update writes memory", int'(mem[1][0]), 3);
        op(0, 1'b0, 8'd0, '0);                 // R5 re-supply vs R6 hit
        cnt_chk(4, 3, "R5 R6");
        op(1, 1'b1, 8'd1, 16'h0009);           // R7 neighbour word
        cnt_chk(5, 4, "R7 R6");
        op(0, 1'b1, 8'd2, 16'h0007);           // R7 false sharing from port 0
        cnt_chk(7, 5, "R7");
        op(1, 1'b0, 8'd2, '0);
        cnt_chk(8, 5, "R7 R5");
        op(1, 1'b0, 8'd1, '0);
        cnt_chk(8, 5, "R6 shared hit");
        op(0, 1'b1, 8'd64, 16'h00AA);          // R8 clean victim, fill only
        cnt_chk(9, 6, "R8");
        chk(mem[0][64] == 16'h1040 && mem[1][64] == 16'h1040, "R3 memory stale before evict", int'(mem[0][64]), 'h1040);
        op(0, 1'b0, 8'd128, '0);               // R8 dirty victim, write-back + fill
        cnt_chk(11, 8, "R8");
        chk(mem[0][64] == 16'h00AA && mem[1][64] == 16'h00AA, "R8 victim written back", int'(mem[0][64]), 'hAA);
        op(1, 1'b0, 8'd64, '0);
        cnt_chk(12, 9, "R8");

        // R9 simultaneous requests
        @(negedge clk);
        issue(0, 1'b0, 8'd4, '0);
        issue(1, 1'b0, 8'd8, '0);
        fork
            wait_rdy(0, 0);
            wait_rdy(0, 1);
            wait_rdy(1, 0);
            wait_rdy(1, 1);
        join
        chk(t_done[0][0] < t_done[0][1], "R9 port 0 first (invalidate)", int'(t_done[0][0]), int'(t_done[0][1]));
        chk(t_done[1][0] < t_done[1][1], "R9 port 0 first (update)", int'(t_done[1][0]), int'(t_done[1][1]));
        cnt_chk(14, 11, "R10");
        chk(sb_q[0].size() + sb_q[1].size() + sb_q[2].size() + sb_q[3].size() == 0,
            "R2 every read answered", 1, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule